// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register Front End

This block sits between a bytewide host bus and a real-time clock counter chain. The host sees one flat byte address space. The eight highest addresses hold the clock registers. Every lower address reaches a plain byte array. The counter chain is a separate block: it supplies the current time as eight BCD bytes together with a one-second tick, and it accepts a load strobe with a new time.

The host never reads the counters directly. It reads a visible copy, which takes all eight counter bytes in one cycle on each tick. Two control bits in the century register change this. A READ flag freezes the copy so that a multi-byte read stays consistent, while the counters keep running. A WRITE flag also freezes the copy and opens it to host writes. When WRITE is cleared, the whole copy is handed to the counter chain in a single load pulse. A power-good input deselects the block completely while the supply is out of tolerance.

The bus strobes are active-low chip enable, output enable and write enable, plus an active-high second enable. They are sampled on the system clock. A write takes effect on each rising clock edge at which the write conditions hold. Read data is combinational from the strobes and the address. The bus is split into an input, an output and an output-enable.

Top module: `tkram_front`

## Requirements
- R1: An access is enabled only when `pwr_good_i`=1, `ce_n_i`=0 and `ce2_i`=1. `dq_oe_o` is 1 exactly when an access is enabled with `oe_n_i`=0 and `we_n_i`=1. Whenever `dq_oe_o` is 0, `dq_o` is 0.
- R2: Addresses below the top eight hit a byte array indexed by the low `RAM_AW` address bits; higher bits alias. A write at one clock edge is visible to a read in the next cycle. This holds whatever the state of READ and WRITE.
- R3: The clock registers occupy offsets 0..7 above address 2^ADDR_W-8, in this order: 0 control/century, 1 day, 2 date, 3 month, 4 year, 5 hours, 6 minutes, 7 seconds. Offset k≥1 reads byte k of the visible copy. Offset 0 reads {WRITE, READ, century[5:0]}, where WRITE is bit 7 and READ is bit 6.
- R4: When READ=0 and WRITE=0, a cycle with `tick_i`=1 makes all eight visible bytes equal `cnt_time_i` at the next edge. Byte k is `cnt_time_i[8k+7:8k]`, and bits 7:6 of byte 0 are discarded.
- R5: While READ=1, ticks leave the visible copy unchanged.
- R6: After READ is written to 0 (with WRITE=0), the copy stays frozen until the next tick. That tick loads the count that is current at the tick.
- R7: While WRITE=1, ticks are ignored and host writes to offsets 1..7 store into the visible copy. A century-register write stores its century field when WRITE was already 1 or is being set by that same write.
- R8: With WRITE=0, host writes to offsets 1..7 leave the visible copy unchanged.
- R9: A century-register write that clears WRITE from 1 raises `load_o` for exactly one cycle, starting after that edge. During that cycle `load_time_o` holds the visible copy, with bits 7:6 of byte 0 at 0. At all other times `load_o` is 0.
- R10: While `pwr_good_i`=0, writes change neither the array nor any clock register, and `dq_oe_o` stays 0.
- R11: After reset, READ, WRITE and all visible bytes are 0, and `load_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply within tolerance |
| ce_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Second chip enable, active high |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| dq_i | input | 8 | Write data from host |
| dq_o | output | 8 | Read data to host |
| dq_oe_o | output | 1 | Host bus drive enable |
| tick_i | input | 1 | One-second tick from counter chain |
| cnt_time_i | input | 64 | Current counter time, byte k = register offset k |
| load_o | output | 1 | Load strobe to counter chain |
| load_time_o | output | 64 | Time to load, byte k = register offset k |

## Verification
A wrongly held or wrongly cleared READ or WRITE flag appears at offset 0 on the very next read. It also shows up at the first tick as a copy that moves when it should hold, or holds when it should move. A byte missed in the single-cycle refresh reads stale immediately after that tick, and a bad load decision shows as a missing, repeated or mis-valued `load_o` pulse in the cycle after WRITE is cleared. Array aliasing or decode errors show as a wrong value on the read that follows a full sweep of addresses.

// File: rtl/tkram_pkg.sv
package tkram_pkg;
   localparam int BYTE_W   = 8;
   localparam int NREG     = 8;
   localparam int OFF_W    = $clog2(NREG);
   localparam int TIME_W   = BYTE_W * NREG;
   localparam int WR_BIT   = 7;
   localparam int RD_BIT   = 6;
   localparam int CENT_W   = 6;
   localparam logic [BYTE_W-1:0] CENT_MASK = BYTE_W'((1 << CENT_W) - 1);

   typedef enum logic [OFF_W-1:0] {
      OFF_CTL  = 3'd0,
      OFF_DAY  = 3'd1,
      OFF_DATE = 3'd2,
      OFF_MON  = 3'd3,
      OFF_YEAR = 3'd4,
      OFF_HOUR = 3'd5,
      OFF_MIN  = 3'd6,
      OFF_SEC  = 3'd7
   } tk_off_e;
endpackage

// File: rtl/tkram_decode.sv
module tkram_decode
   import tkram_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              pwr_good_i,
   input  logic              ce_n_i,
   input  logic              ce2_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_o,
   output logic              rd_o,
   output logic              clk_sel_o,
   output tk_off_e           off_o
);
   logic acc;

   assign acc       = pwr_good_i & ~ce_n_i & ce2_i;
   assign wr_o      = acc & ~we_n_i;
   assign rd_o      = acc & ~oe_n_i & we_n_i;
   assign clk_sel_o = &addr_i[ADDR_W-1:OFF_W];
   assign off_o     = tk_off_e'(addr_i[OFF_W-1:0]);
endmodule

// File: rtl/tkram_ram.sv
module tkram_ram
   import tkram_pkg::*;
#(
   parameter int RAM_AW  = 10,
   parameter bit RAM_CLR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [RAM_AW-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << RAM_AW;

   logic [BYTE_W-1:0] mem [DEPTH];

   generate
      if (RAM_CLR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we_i) begin
               mem[addr_i] <= wdata_i;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we_i) mem[addr_i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = mem[addr_i];
endmodule

// File: rtl/tkram_shadow.sv
module tkram_shadow
   import tkram_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              clk_sel_i,
   input  tk_off_e           off_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] cnt_time_i,
   output logic [TIME_W-1:0] vis_o,
   output logic              wflag_o,
   output logic              rflag_o,
   output logic              load_o
);
   logic wflag, rflag, load_q;
   logic ctl_wr, refresh;
   logic [NREG-1:0] host_wr;

   assign ctl_wr  = wr_i & clk_sel_i & (off_i == OFF_CTL);
   assign refresh = tick_i & ~rflag & ~wflag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wflag  <= 1'b0;
         rflag  <= 1'b0;
         load_q <= 1'b0;
      end else begin
         load_q <= ctl_wr & wflag & ~wdata_i[WR_BIT];
         if (ctl_wr) begin
            wflag <= wdata_i[WR_BIT];
            rflag <= wdata_i[RD_BIT];
         end
      end
   end

   genvar k;
   generate
      for (k = 0; k < NREG; k++) begin : g_byte
         logic [BYTE_W-1:0] q;
         logic [BYTE_W-1:0] src_cnt;
         logic [BYTE_W-1:0] src_host;

         if (k == 0) begin : g_cent
            assign host_wr[k] = ctl_wr & (wflag | wdata_i[WR_BIT]);
            assign src_cnt    = cnt_time_i[k*BYTE_W +: BYTE_W] & CENT_MASK;
            assign src_host   = wdata_i & CENT_MASK;
         end else begin : g_time
            assign host_wr[k] = wr_i & clk_sel_i & (off_i == tk_off_e'(k)) & wflag;
            assign src_cnt    = cnt_time_i[k*BYTE_W +: BYTE_W];
            assign src_host   = wdata_i;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= '0;
            else if (host_wr[k]) q <= src_host;
            else if (refresh)    q <= src_cnt;
         end

         assign vis_o[k*BYTE_W +: BYTE_W] = q;
      end
   endgenerate

   assign wflag_o = wflag;
   assign rflag_o = rflag;
   assign load_o  = load_q;

   AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rflag && !wflag && !wr_i) |=> $stable(vis_o)); // R5

   AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!rflag && !wflag && tick_i && !wr_i)
      |=> (vis_o == ($past(cnt_time_i) & {{(TIME_W-BYTE_W){1'b1}}, CENT_MASK}))); // R4

   AST_TIME_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!wflag && !tick_i && wr_i && clk_sel_i && off_i != OFF_CTL)
      |=> $stable(vis_o)); // R8

   AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o); // R9

   AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> (!wflag && $past(wflag))); // R9
endmodule

// File: rtl/tkram_front.sv
module tkram_front
   import tkram_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int RAM_AW  = 10,
   parameter bit RAM_CLR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good_i,
   input  logic              ce_n_i,
   input  logic              ce2_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] dq_i,
   output logic [BYTE_W-1:0] dq_o,
   output logic              dq_oe_o,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] cnt_time_i,
   output logic              load_o,
   output logic [TIME_W-1:0] load_time_o
);
   generate
      if (ADDR_W < OFF_W + 1 || RAM_AW < 1 || RAM_AW > ADDR_W) begin : g_bad_cfg
         $error("tkram_front: ADDR_W/RAM_AW combination not supported");
      end
   endgenerate

   logic              wr, rd, clk_sel;
   tk_off_e           off;
   logic [BYTE_W-1:0] ram_q, clk_q, rsel;
   logic [TIME_W-1:0] vis;
   logic              wflag, rflag;

   tkram_decode #(.ADDR_W(ADDR_W)) u_dec (
      .pwr_good_i (pwr_good_i),
      .ce_n_i     (ce_n_i),
      .ce2_i      (ce2_i),
      .oe_n_i     (oe_n_i),
      .we_n_i     (we_n_i),
      .addr_i     (addr_i),
      .wr_o       (wr),
      .rd_o       (rd),
      .clk_sel_o  (clk_sel),
      .off_o      (off)
   );

   tkram_ram #(.RAM_AW(RAM_AW), .RAM_CLR(RAM_CLR)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr & ~clk_sel),
      .addr_i  (addr_i[RAM_AW-1:0]),
      .wdata_i (dq_i),
      .rdata_o (ram_q)
   );

   tkram_shadow u_shd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr),
      .clk_sel_i  (clk_sel),
      .off_i      (off),
      .wdata_i    (dq_i),
      .tick_i     (tick_i),
      .cnt_time_i (cnt_time_i),
      .vis_o      (vis),
      .wflag_o    (wflag),
      .rflag_o    (rflag),
      .load_o     (load_o)
   );

   always_comb begin
      if (off == OFF_CTL) clk_q = {wflag, rflag, vis[CENT_W-1:0]};
      else                clk_q = vis[off*BYTE_W +: BYTE_W];
   end

   assign rsel        = clk_sel ? clk_q : ram_q;
   assign dq_oe_o     = rd;
   assign dq_o        = rd ? rsel : '0;
   assign load_time_o = vis;

   AST_QUIET_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good_i |-> !dq_oe_o); // R10

   AST_NO_LOAD_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good_i |=> !load_o); // R10

   AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_o |-> (we_n_i && !oe_n_i)); // R1
endmodule

// File: tb/tkram_front_test.sv
module tkram_front_test;
   localparam int AW  = 13;
   localparam int RAW = 6;
   localparam logic [AW-1:0] CBASE = 13'h1FF8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b1;
   logic        ce_n = 1'b1, ce2 = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]  dq_i = '0;
   logic [7:0]  dq_o;
   logic        dq_oe;
   logic        tick = 1'b0;
   logic [63:0] cnt = '0;
   logic        load;
   logic [63:0] load_time;

   int n_run = 0;
   int n_fail = 0;

   tkram_front #(.ADDR_W(AW), .RAM_AW(RAW)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good),
      .ce_n_i(ce_n), .ce2_i(ce2), .oe_n_i(oe_n), .we_n_i(we_n),
      .addr_i(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe),
      .tick_i(tick), .cnt_time_i(cnt), .load_o(load), .load_time_o(load_time)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [63:0] mk(input int s);
      logic [63:0] t;
      t[7:0]   = 8'hE0;
      t[15:8]  = 8'h03;
      t[23:16] = 8'h15;
      t[31:24] = 8'h06;
      t[39:32] = 8'h24;
      t[47:40] = bcd((s / 3600) % 24);
      t[55:48] = bcd((s / 60) % 60);
      t[63:56] = bcd(s % 60);
      return t;
   endfunction

   task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; dq_i = d; ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = a; ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1;
      #2;
      d = dq_o; oe = dq_oe;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic do_tick(input int s);
      @(negedge clk);
      cnt = mk(s); tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic chk_clock(input string req, input logic [63:0] expv, input logic [1:0] fl);
      logic [7:0] d;
      logic oe;
      for (int k = 0; k < 8; k++) begin
         bus_rd(CBASE + AW'(k), d, oe);
         if (k == 0) chk(req, {56'd0, d}, {56'd0, fl, expv[5:0]});
         else        chk(req, {56'd0, d}, {56'd0, expv[8*k +: 8]});
      end
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      logic oe;
      logic [63:0] wexp;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state, R3 map
      chk("R11 load", {63'd0, load}, 64'd0);
      chk_clock("R11 R3 reset regs", 64'd0, 2'b00);

      // R1 enable decode
      @(negedge clk);
      addr = 13'h0005; ce_n = 1'b0; ce2 = 1'b0; oe_n = 1'b0; we_n = 1'b1; #2;
      chk("R1 ce2 low", {55'd0, dq_oe, dq_o}, 64'd0);
      ce2 = 1'b1; ce_n = 1'b1; #2;
      chk("R1 ce_n high", {55'd0, dq_oe, dq_o}, 64'd0);
      ce_n = 1'b0; oe_n = 1'b1; #2;
      chk("R1 oe_n high", {55'd0, dq_oe, dq_o}, 64'd0);
      oe_n = 1'b0; #2;
      chk("R1 read drives", {63'd0, dq_oe}, 64'd1);
      ce_n = 1'b1; oe_n = 1'b1;

      // R2 exhaustive array sweep with aliasing
      for (int i = 0; i < 64; i++) bus_wr(AW'(i), 8'((i * 37 + 5) & 8'hFF));
      for (int i = 0; i < 64; i++) begin
         bus_rd(AW'(i), d, oe);
         chk("R2 sweep", {56'd0, d}, {56'd0, 8'((i * 37 + 5) & 8'hFF)});
         bus_rd(AW'(i + 64 * (i % 7 + 1)), d, oe);
         chk("R2 alias", {56'd0, d}, {56'd0, 8'((i * 37 + 5) & 8'hFF)});
      end

      // R4 refresh on tick, century bits 7:6 dropped
      do_tick(3723);
      chk_clock("R4 refresh", mk(3723), 2'b00);

      // R5 freeze
      bus_wr(CBASE, 8'h60);
      bus_rd(CBASE, d, oe);
      chk("R5 R3 read flag", {56'd0, d}, {56'd0, 8'h60});
      for (int s = 3724; s < 3729; s++) do_tick(s);
      chk_clock("R5 frozen", mk(3723), 2'b01);
      bus_wr(13'h0007, 8'hA5);  // R2 array write while frozen
      bus_rd(13'h0007, d, oe);
      chk("R2 write while READ", {56'd0, d}, {56'd0, 8'hA5});

      // R6 release, then next tick
      bus_wr(CBASE, 8'h20);
      chk_clock("R6 before tick", mk(3723), 2'b00);
      do_tick(3790);
      chk_clock("R6 after tick", mk(3790), 2'b00);

      // R8 time writes ignored without WRITE
      for (int k = 1; k < 8; k++) bus_wr(CBASE + AW'(k), 8'h99);
      chk_clock("R8 ignored", mk(3790), 2'b00);

      // R7 host load via WRITE
      bus_wr(CBASE, 8'hA1);
      wexp = {8'h59, 8'h58, 8'h23, 8'h99, 8'h12, 8'h31, 8'h07, 8'h21};
      for (int k = 1; k < 8; k++) bus_wr(CBASE + AW'(k), wexp[8*k +: 8]);
      do_tick(10);
      chk_clock("R7 held", wexp, 2'b10);
      chk("R9 no early load", {63'd0, load}, 64'd0);

      // R9 load pulse on WRITE falling
      bus_wr(CBASE, 8'h21);
      chk("R9 load high", {63'd0, load}, 64'd1);
      chk("R9 load value", load_time, wexp);
      @(negedge clk);
      chk("R9 load single", {63'd0, load}, 64'd0);
      bus_wr(CBASE, 8'h21);
      chk("R9 no repeat", {63'd0, load}, 64'd0);

      // R10 unpowered
      @(negedge clk); pwr_good = 1'b0;
      bus_wr(13'h0003, 8'h3C);
      bus_wr(CBASE, 8'h40);
      bus_wr(CBASE + 13'd7, 8'h11);
      bus_rd(13'h0003, d, oe);
      chk("R10 no drive", {55'd0, oe, d}, 64'd0);
      @(negedge clk); pwr_good = 1'b1;
      bus_rd(13'h0003, d, oe);
      chk("R10 array kept", {56'd0, d}, {56'd0, 8'((3 * 37 + 5) & 8'hFF)});
      chk_clock("R10 clock kept", wexp, 2'b00);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule